// File: doc/BRIEF.md
# Mode-Aware Compare Output Generator

This block turns a running timer count into up to three waveform pins. Each of its three channels compares the shared count with its own compare value and drives one pin, using a 2-bit action code per channel. The same code means different things depending on the counting mode class that is presented with it. In the plain (non-PWM) class, a match sets, clears or toggles the pin. In the single-slope PWM class, a match moves the pin one way and the wrap back to zero moves it the other way. In the dual-slope PWM class, the way a match moves the pin depends on whether the count is rising or falling.

An external counter supplies the count value, its direction, and one-cycle strobes that mark the top and bottom of the count. The mode class is shared by all channels. Each channel keeps an active copy of its compare value. In the plain class this copy follows the input every cycle. In the PWM classes it is reloaded only on a top strobe, so a value written mid-period cannot cut a pulse short. The pin follows a two-state machine per channel, with states PIN_LO and PIN_HI. The SET event and the TOGGLE event move PIN_LO to PIN_HI. The CLEAR event and the TOGGLE event move PIN_HI to PIN_LO. With no event, the state stays where it is.

Top module: `cmp_wave_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every pin and every match strobe is 0 after that edge, and every active compare value becomes 0.
- R2: A channel's match strobe is high for exactly the cycle after a cycle in which `count` equals that channel's active compare value, in every mode class and for every action code.
- R3: Mode class 0 (plain): on a match the pin is unchanged for action 00, toggled for 01, cleared for 10 and set for 11. The new level appears after the clock edge that ends the matching cycle.
- R4: Mode class 1 (single-slope PWM): action 10 clears the pin on a match and sets it in a cycle with `at_bottom` high. Action 11 sets the pin on a match and clears it on `at_bottom`.
- R5: Mode class 2 (dual-slope PWM): action 10 clears the pin on a match while `count_up` is 1 and sets it on a match while `count_up` is 0. Action 11 does the reverse.
- R6: The pin holds its level for action 00 in any class, for action 01 in classes 1 and 2, and for any action in the reserved class 3.
- R7: In class 1, when a match and `at_bottom` fall in the same cycle, the match action decides the pin.
- R8: In class 0, the active compare value takes the input compare value at every clock edge. A new value is therefore compared from the next cycle on.
- R9: In classes 1, 2 and 3, the active compare value is reloaded from the input only at an edge that ends a cycle with `at_top` high. Otherwise it keeps its old value.
- R10: The three channels act independently, each using only its own action code and compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count | input | 16 | Running count from the counter |
| count_up | input | 1 | 1 while the count is rising |
| at_top | input | 1 | Count is at its top value this cycle |
| at_bottom | input | 1 | Count is at zero this cycle |
| mode | input | 2 | Mode class: 0 plain, 1 single-slope, 2 dual-slope, 3 reserved |
| act_a | input | 2 | Action code for channel A |
| act_b | input | 2 | Action code for channel B |
| act_c | input | 2 | Action code for channel C |
| cmp_a | input | 16 | Compare value for channel A |
| cmp_b | input | 16 | Compare value for channel B |
| cmp_c | input | 16 | Compare value for channel C |
| wave_a | output | 1 | Waveform pin, channel A |
| wave_b | output | 1 | Waveform pin, channel B |
| wave_c | output | 1 | Waveform pin, channel C |
| match_a | output | 1 | Match strobe, channel A |
| match_b | output | 1 | Match strobe, channel B |
| match_c | output | 1 | Match strobe, channel C |

## Verification
Both the pin and the match strobe for a matching cycle are due one clock edge after that cycle. A compare value written in the plain class is first compared one cycle after it is presented. In a PWM class, a written value waits for the next top strobe and is compared from the cycle after it. The bench drives inputs on the falling edge and keeps a behavioural model that it advances on each rising edge. It compares all six outputs with that model on the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;
    typedef enum logic [1:0] {
        MC_PLAIN  = 2'd0,
        MC_SINGLE = 2'd1,
        MC_DUAL   = 2'd2,
        MC_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_LOW    = 2'd2,
        ACT_HIGH   = 2'd3
    } act_e;

    typedef enum logic {
        PIN_LO = 1'b0,
        PIN_HI = 1'b1
    } pin_state_e;

    typedef struct packed {
        logic set_ev;
        logic clr_ev;
        logic tgl_ev;
    } pin_ev_t;
endpackage

// File: rtl/cmpw_shadow.sv
module cmpw_shadow
    import cmpw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             at_top,
    input  logic [CNT_W-1:0] cmp_in,
    output logic [CNT_W-1:0] active
);
    logic load;

    always_comb begin
        load = (mode == MC_PLAIN) || at_top;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= '0;
        else if (load)
            active <= cmp_in;
    end

    // R9: outside the plain class, the active value moves only after a top strobe
    a_r9_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MC_PLAIN && !at_top) |=> $stable(active));

    // R8: in the plain class, the active value follows the input one edge later
    a_r8_plain_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MC_PLAIN) |=> (active == $past(cmp_in)));
endmodule

// File: rtl/cmpw_decode.sv
module cmpw_decode
    import cmpw_pkg::*;
(
    input  mode_e   mode,
    input  act_e    action,
    input  logic    hit,
    input  logic    count_up,
    input  logic    at_bottom,
    output pin_ev_t ev
);
    always_comb begin
        ev = '0;
        unique case (mode)
            MC_PLAIN: begin
                if (hit) begin
                    unique case (action)
                        ACT_NONE:   ;
                        ACT_TOGGLE: ev.tgl_ev = 1'b1;
                        ACT_LOW:    ev.clr_ev = 1'b1;
                        ACT_HIGH:   ev.set_ev = 1'b1;
                    endcase
                end
            end
            MC_SINGLE: begin
                // a match outranks the wrap to zero (R7)
                if (hit) begin
                    if (action == ACT_LOW)  ev.clr_ev = 1'b1;
                    if (action == ACT_HIGH) ev.set_ev = 1'b1;
                end else if (at_bottom) begin
                    if (action == ACT_LOW)  ev.set_ev = 1'b1;
                    if (action == ACT_HIGH) ev.clr_ev = 1'b1;
                end
            end
            MC_DUAL: begin
                if (hit) begin
                    if (action == ACT_LOW) begin
                        ev.clr_ev = count_up;
                        ev.set_ev = !count_up;
                    end
                    if (action == ACT_HIGH) begin
                        ev.set_ev = count_up;
                        ev.clr_ev = !count_up;
                    end
                end
            end
            MC_RSVD: ;
        endcase
    end
endmodule

// File: rtl/cmpw_pin_fsm.sv
module cmpw_pin_fsm
    import cmpw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  mode_e   mode,
    input  act_e    action,
    input  logic    hit,
    input  logic    at_bottom,
    input  pin_ev_t ev,
    output logic    pin
);
    pin_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LO: if (ev.set_ev || ev.tgl_ev) state_d = PIN_HI;
            PIN_HI: if (ev.clr_ev || ev.tgl_ev) state_d = PIN_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PIN_LO;
        else
            state_q <= state_d;
    end

    always_comb begin
        pin = (state_q == PIN_HI);
    end

    // R3: plain-class toggle inverts the pin
    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MC_PLAIN && action == ACT_TOGGLE && hit) |=> (pin != $past(pin)));

    // R6: no-change codes and the reserved class leave the pin alone
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_NONE || mode == MC_RSVD ||
         (mode != MC_PLAIN && action == ACT_TOGGLE)) |=> $stable(pin));

    // R4: single-slope wrap sets the pin for action 10 when no match is present
    a_r4_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MC_SINGLE && action == ACT_LOW && at_bottom && !hit) |=> pin);

    // R7: a match at the bottom decides the pin
    a_r7_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MC_SINGLE && action == ACT_LOW && at_bottom && hit) |=> !pin);
endmodule

// File: rtl/cmpw_channel.sv
module cmpw_channel
    import cmpw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             count_up,
    input  logic             at_top,
    input  logic             at_bottom,
    input  mode_e            mode,
    input  act_e             action,
    input  logic [CNT_W-1:0] cmp_in,
    output logic             pin,
    output logic             match
);
    logic [CNT_W-1:0] active;
    logic             hit;
    pin_ev_t          ev;

    cmpw_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .at_top (at_top),
        .cmp_in (cmp_in),
        .active (active)
    );

    always_comb begin
        hit = (count == active);
    end

    cmpw_decode u_decode (
        .mode      (mode),
        .action    (action),
        .hit       (hit),
        .count_up  (count_up),
        .at_bottom (at_bottom),
        .ev        (ev)
    );

    cmpw_pin_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .action    (action),
        .hit       (hit),
        .at_bottom (at_bottom),
        .ev        (ev),
        .pin       (pin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            match <= 1'b0;
        else
            match <= hit;
    end

    // R2: a strobe means the count equalled the active value one cycle earlier
    a_r2_match_cause: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ($past(count) == $past(active)));
endmodule

// File: rtl/cmp_wave_gen.sv
module cmp_wave_gen
    import cmpw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             count_up,
    input  logic             at_top,
    input  logic             at_bottom,
    input  logic [1:0]       mode,
    input  logic [1:0]       act_a,
    input  logic [1:0]       act_b,
    input  logic [1:0]       act_c,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cmp_c,
    output logic             wave_a,
    output logic             wave_b,
    output logic             wave_c,
    output logic             match_a,
    output logic             match_b,
    output logic             match_c
);
    localparam int N_CH = 3;

    logic [N_CH-1:0][1:0]       act_v;
    logic [N_CH-1:0][CNT_W-1:0] cmp_v;
    logic [N_CH-1:0]            wave_v;
    logic [N_CH-1:0]            match_v;
    mode_e                      mode_t;

    always_comb begin
        mode_t   = mode_e'(mode);
        act_v[0] = act_a;
        act_v[1] = act_b;
        act_v[2] = act_c;
        cmp_v[0] = cmp_a;
        cmp_v[1] = cmp_b;
        cmp_v[2] = cmp_c;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        cmpw_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .count     (count),
            .count_up  (count_up),
            .at_top    (at_top),
            .at_bottom (at_bottom),
            .mode      (mode_t),
            .action    (act_e'(act_v[g])),
            .cmp_in    (cmp_v[g]),
            .pin       (wave_v[g]),
            .match     (match_v[g])
        );
    end

    always_comb begin
        wave_a  = wave_v[0];
        wave_b  = wave_v[1];
        wave_c  = wave_v[2];
        match_a = match_v[0];
        match_b = match_v[1];
        match_c = match_v[2];
    end
endmodule

// File: tb/test_cmp_wave_gen.sv
module test_cmp_wave_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count = '0;
    logic        count_up = 1'b1, at_top = 1'b0, at_bottom = 1'b1;
    logic [1:0]  mode = 2'd0, act_a = 2'd0, act_b = 2'd0, act_c = 2'd0;
    logic [15:0] cmp_a = '0, cmp_b = '0, cmp_c = '0;
    logic        wave_a, wave_b, wave_c, match_a, match_b, match_c;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int c_val = 0, top_val = 15;
    bit up_dir = 1'b1;
    string scen = "R1";

    int m_act [3];
    bit m_pin [3];
    bit m_match [3];

    always #10 clk = ~clk;

    cmp_wave_gen i_cmp_wave_gen (
        .clk(clk), .rst_n(rst_n), .count(count), .count_up(count_up),
        .at_top(at_top), .at_bottom(at_bottom), .mode(mode),
        .act_a(act_a), .act_b(act_b), .act_c(act_c),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
        .wave_a(wave_a), .wave_b(wave_b), .wave_c(wave_c),
        .match_a(match_a), .match_b(match_b), .match_c(match_c)
    );

    // behavioural reference, advanced at every rising edge
    always @(posedge clk) begin
        int acts [3];
        int cmps [3];
        acts = '{int'(act_a), int'(act_b), int'(act_c)};
        cmps = '{int'(cmp_a), int'(cmp_b), int'(cmp_c)};
        for (int i = 0; i < 3; i++) begin
            if (!rst_n) begin
                m_act[i] = 0; m_pin[i] = 0; m_match[i] = 0;
            end else begin
                bit hit;
                hit = (int'(count) == m_act[i]);
                m_match[i] = hit;
                if (mode == 2'd0 && hit) begin
                    if (acts[i] == 1) m_pin[i] = !m_pin[i];
                    if (acts[i] == 2) m_pin[i] = 0;
                    if (acts[i] == 3) m_pin[i] = 1;
                end else if (mode == 2'd1) begin
                    if (hit && acts[i] == 2) m_pin[i] = 0;
                    else if (hit && acts[i] == 3) m_pin[i] = 1;
                    else if (!hit && at_bottom && acts[i] == 2) m_pin[i] = 1;
                    else if (!hit && at_bottom && acts[i] == 3) m_pin[i] = 0;
                end else if (mode == 2'd2 && hit) begin
                    if (acts[i] == 2) m_pin[i] = !count_up;
                    if (acts[i] == 3) m_pin[i] = count_up;
                end
                if (mode == 2'd0 || at_top) m_act[i] = cmps[i];
            end
        end
    end

    function automatic string wave_tag(int ch);
        int a;
        a = (ch == 0) ? int'(act_a) : (ch == 1) ? int'(act_b) : int'(act_c);
        if (a == 0 || mode == 2'd3 || (mode != 2'd0 && a == 1)) return "R6";
        if (mode == 2'd0) return "R3";
        if (mode == 2'd1) return "R4";
        return "R5";
    endfunction

    task automatic check_bit(string tag, string what, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s/%s %s cycle %0d: got %0b expected %0b", tag, scen, what, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        check_bit(wave_tag(0), "wave_a", wave_a, m_pin[0]);
        check_bit(wave_tag(1), "wave_b", wave_b, m_pin[1]);
        check_bit(wave_tag(2), "wave_c", wave_c, m_pin[2]);
        check_bit("R2", "match_a", match_a, m_match[0]);
        check_bit("R2", "match_b", match_b, m_match[1]);
        check_bit("R2", "match_c", match_c, m_match[2]);
    endtask

    task automatic advance_count();
        if (mode == 2'd2) begin
            if (up_dir && c_val == top_val) begin up_dir = 0; c_val = c_val - 1; end
            else if (up_dir) c_val = c_val + 1;
            else begin c_val = c_val - 1; if (c_val == 0) up_dir = 1; end
        end else begin
            c_val = (c_val == top_val) ? 0 : c_val + 1;
            up_dir = 1;
        end
        count = 16'(c_val); count_up = up_dir;
        at_top = (c_val == top_val); at_bottom = (c_val == 0);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cyc++;
            compare_all();
            advance_count();
        end
    endtask

    task automatic restart(logic [1:0] m);
        mode = m; c_val = 0; up_dir = 1;
        count = '0; count_up = 1; at_top = 0; at_bottom = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of all outputs
        check_bit("R1", "wave_a", wave_a, 0); check_bit("R1", "wave_b", wave_b, 0);
        check_bit("R1", "wave_c", wave_c, 0); check_bit("R1", "match_a", match_a, 0);
        check_bit("R1", "match_b", match_b, 0); check_bit("R1", "match_c", match_c, 0);
        rst_n = 1;

        // R3 and R10: plain class, three different actions at once
        scen = "R3"; restart(2'd0);
        act_a = 2'd1; cmp_a = 16'd5; act_b = 2'd2; cmp_b = 16'd3;
        act_c = 2'd3; cmp_c = 16'd8;
        run(40);
        // R8: new compare value takes effect on the next cycle
        scen = "R8"; cmp_a = 16'd9; act_b = 2'd3; act_c = 2'd2;
        run(40);
        scen = "R10"; act_a = 2'd0; act_b = 2'd1; cmp_b = 16'd15;
        run(35);

        // R4: single-slope
        scen = "R4"; top_val = 12; restart(2'd1);
        act_a = 2'd2; cmp_a = 16'd4; act_b = 2'd3; cmp_b = 16'd7;
        act_c = 2'd1; cmp_c = 16'd2;
        run(30);
        // R9: compare values written mid-period wait for the top strobe
        scen = "R9"; cmp_a = 16'd10; cmp_b = 16'd2;
        run(30);
        // R7: match at the bottom decides
        scen = "R7"; act_c = 2'd2; cmp_c = 16'd0; cmp_a = 16'd0; act_a = 2'd3;
        run(40);

        // R5: dual-slope
        scen = "R5"; top_val = 10; restart(2'd2);
        act_a = 2'd2; cmp_a = 16'd3; act_b = 2'd3; cmp_b = 16'd6;
        act_c = 2'd0; cmp_c = 16'd5;
        run(45);
        scen = "R9"; cmp_a = 16'd8; cmp_b = 16'd1; act_c = 2'd1;
        run(45);
        scen = "R5"; cmp_a = 16'd10; cmp_b = 16'd0;
        run(45);

        // R6: reserved class holds every pin
        scen = "R6"; restart(2'd3);
        act_a = 2'd3; act_b = 2'd2; act_c = 2'd1;
        run(30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule